// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with System-Reset Pin Override

This block is a test access port controller for boundary-scan testing of a group of bus pins. It holds the usual sixteen-state test controller, an eight-bit instruction register and three data registers: a one-bit bypass register, a 32-bit identification register, and a boundary register with one output cell and one enable cell per controlled pin. The block sits between the core logic and the pad cells. In normal use the pads follow the core. Under the external-test or clamp instructions the pads take their values from the boundary update stage. Under the high-impedance instruction every enable drops.

An active-low system reset input takes priority over everything else. While it is low, every controlled pin enable is forced off, whatever the instruction or the boundary register holds. Test equipment should therefore keep system reset high whenever it expects boundary-driven pin values. The scan interface is plain test-clock signalling with no flow control, because the test clock sets the pace of every transfer.

Top module: `tapc_top`

## Requirements
- R1: Holding TMS high for five test-clock rising edges puts the controller in Test-Logic-Reset from any state. In that state the instruction becomes IDENTIFY (0x02), which selects the 32-bit identification register.
- R2: In the Capture-IR state the instruction shift stage loads 8'b0000_0001. Bits enter at TDI and leave at TDO least significant first, and the new instruction takes effect in Update-IR.
- R3: Under IDENTIFY, a data scan shifts out the 32-bit IDCODE parameter, least significant bit first. Bit 0 of that value is 1.
- R4: BYPASS (0xFF) and every opcode not listed here select the one-bit bypass register. It captures 0, and each TDI bit reaches TDO one shift later.
- R5: Under SAMPLE (0x01), Capture-DR loads the boundary register with the core output bits in positions 0..N-1 and the core enable bits in positions N..2N-1. While SAMPLE is active the pads follow the core.
- R6: Under EXTEST (0x00) or SAMPLE, Update-DR copies the boundary register into the update stage. Under EXTEST, pad outputs and enables come from the update stage, using the same bit layout as R5.
- R7: CLAMP (0x03) drives the pads from the update stage and selects the bypass register.
- R8: HIGHZ (0x04) forces every pad enable to 0 and selects the bypass register.
- R9: While sys_rst_n is low, every pad enable is 0 under any instruction and any update-stage content.
- R10: tdo_en is 1 only while the controller is in Shift-DR or Shift-IR. TDO and tdo_en change on the falling edge of the test clock.
- R11: A low level on trst_n asynchronously returns the controller to Test-Logic-Reset, with the instruction set to IDENTIFY and the update stage cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | TDO driver enable |
| sys_rst_n | input | 1 | System reset, active low; forces pad enables off |
| core_out | input | NPIN | Output values from the core |
| core_oe | input | NPIN | Output enables from the core |
| pad_out | output | NPIN | Output values to the pad cells |
| pad_oe | output | NPIN | Output enables to the pad cells |

## Verification
The pad outputs are combinational in the instruction, the update stage, the core inputs and sys_rst_n. The bench samples them one nanosecond after the falling edge that follows any change. A new instruction or update-stage value lands on the rising edge in Update-IR or Update-DR, so pad checks are made only after the step that leaves those states. TDO is registered on the falling edge, so each shift step samples it just after that falling edge, and it then shows the bit shifted out at the next rising edge. Random opcodes, core values, scan data and reset levels are compared against bench functions that model the captured patterns and the pad selection.

// File: rtl/tapc_pkg.sv
package tapc_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_t;

  localparam int IR_W = 8;
  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_IDENT  = 8'h02;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'h03;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h04;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'b0000_0001;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_t;
endpackage

// File: rtl/tapc_fsm.sv
module tapc_fsm
  import tapc_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      UPD_IR:  nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TLR;
    else         state <= nxt;
  end

  AST_TLR_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TLR && tms) |=> (state == TLR)); // R1
  AST_SEL_EXITS: assert property (@(posedge tck) disable iff (!trst_n)
    (state == SEL_IR && tms) |=> (state == TLR)); // R1
endmodule

// File: rtl/tapc_ir.sv
module tapc_ir
  import tapc_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic [IR_W-1:0] instr,
  output logic            ir_so
);
  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr    <= '0;
      instr <= OP_IDENT;
    end else begin
      case (state)
        CAP_IR:  sr <= IR_CAPTURE;
        SH_IR:   sr <= {tdi, sr[IR_W-1:1]};
        default: sr <= sr;
      endcase
      if (state == TLR)         instr <= OP_IDENT;
      else if (state == UPD_IR) instr <= sr;
    end
  end

  assign ir_so = sr[0];

  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == CAP_IR) |=> (sr == IR_CAPTURE)); // R2
  AST_IR_RESET_OP: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TLR) |=> (instr == OP_IDENT)); // R1
endmodule

// File: rtl/tapc_dr.sv
module tapc_dr
  import tapc_pkg::*;
#(
  parameter int          NPIN   = 8,
  parameter logic [31:0] IDCODE = 32'h1357_9BDF
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_t        state,
  input  logic [IR_W-1:0]   instr,
  input  logic [NPIN-1:0]   core_out,
  input  logic [NPIN-1:0]   core_oe,
  output logic              dr_so,
  output logic [2*NPIN-1:0] upd
);
  localparam int BW = 2 * NPIN;

  dr_path_t         path;
  logic             byp;
  logic [31:0]      id_sr;
  logic [BW-1:0]    bsr;

  always_comb begin
    case (instr)
      OP_IDENT:             path = PATH_ID;
      OP_EXTEST, OP_SAMPLE: path = PATH_BSR;
      default:              path = PATH_BYP;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp   <= 1'b0;
      id_sr <= '0;
      bsr   <= '0;
      upd   <= '0;
    end else begin
      if (state == CAP_DR) begin
        case (path)
          PATH_ID:  id_sr <= IDCODE;
          PATH_BSR: bsr   <= {core_oe, core_out};
          default:  byp   <= 1'b0;
        endcase
      end else if (state == SH_DR) begin
        case (path)
          PATH_ID:  id_sr <= {tdi, id_sr[31:1]};
          PATH_BSR: bsr   <= {tdi, bsr[BW-1:1]};
          default:  byp   <= tdi;
        endcase
      end
      if (state == UPD_DR && path == PATH_BSR) upd <= bsr;
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_so = id_sr[0];
      PATH_BSR: dr_so = bsr[0];
      default:  dr_so = byp;
    endcase
  end

  AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == CAP_DR && path == PATH_BYP) |=> (byp == 1'b0)); // R4
  AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (path != PATH_BSR) |=> $stable(upd)); // R6
endmodule

// File: rtl/tapc_top.sv
module tapc_top
  import tapc_pkg::*;
#(
  parameter int          NPIN   = 8,
  parameter logic [31:0] IDCODE = 32'h1357_9BDF
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  input  logic            sys_rst_n,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  tap_state_t        state;
  logic [IR_W-1:0]   instr;
  logic              ir_so;
  logic              dr_so;
  logic [2*NPIN-1:0] upd;
  logic [NPIN-1:0]   sel_oe;
  logic              shifting;

  tapc_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tapc_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
                .instr(instr), .ir_so(ir_so));

  tapc_dr #(.NPIN(NPIN), .IDCODE(IDCODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .instr(instr),
    .core_out(core_out), .core_oe(core_oe), .dr_so(dr_so), .upd(upd));

  assign shifting = (state == SH_DR) || (state == SH_IR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (state == SH_IR) ? ir_so : dr_so;
      tdo_en <= shifting;
    end
  end

  always_comb begin
    case (instr)
      OP_EXTEST, OP_CLAMP: begin
        pad_out = upd[NPIN-1:0];
        sel_oe  = upd[2*NPIN-1:NPIN];
      end
      OP_HIGHZ: begin
        pad_out = core_out;
        sel_oe  = '0;
      end
      default: begin
        pad_out = core_out;
        sel_oe  = core_oe;
      end
    endcase
    pad_oe = sys_rst_n ? sel_oe : '0;
  end

  AST_RST_TRISTATE: assert property (@(posedge tck) disable iff (!trst_n)
    !sys_rst_n |-> (pad_oe == '0)); // R9
  AST_HIGHZ_OFF: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == OP_HIGHZ) |-> (pad_oe == '0)); // R8
  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> shifting); // R10
  AST_CLAMP_DRIVE: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == OP_CLAMP && sys_rst_n) |-> (pad_oe == upd[2*NPIN-1:NPIN])); // R7
endmodule

// File: tb/tapc_top_test.sv
module tapc_top_test;
  localparam int          N  = 8;
  localparam logic [31:0] ID = 32'h1357_9BDF;

  logic tck = 1'b0;
  logic trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, sys_rst_n = 1'b1;
  logic tdo, tdo_en;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;

  int total = 0, bad = 0;
  logic last_tdo, last_en;
  logic [7:0]   cur_op;
  logic [2*N-1:0] upd_m;

  tapc_top #(.NPIN(N), .IDCODE(ID)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .sys_rst_n(sys_rst_n), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  always #4 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    last_tdo = tdo; last_en = tdo_en;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  // from Run-Test/Idle, back to Run-Test/Idle
  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
    bit en_ok = 1;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i]); cap[i] = last_tdo; if (!last_en) en_ok = 0;
    end
    step(1, 0); step(0, 0);
    chk(en_ok, "R10 tdo_en in Shift-IR", 64'(en_ok), 64'd1);
    cur_op = op;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]); dout[i] = last_tdo;
    end
    step(1, 0); step(0, 0);
    if (cur_op == 8'h00 || cur_op == 8'h01) upd_m = din[2*N-1:0];
  endtask

  function automatic logic [N-1:0] exp_oe(input logic [7:0] op, input logic [2*N-1:0] u,
                                          input logic [N-1:0] coe, input logic r);
    if (!r) return '0;
    case (op)
      8'h00, 8'h03: return u[2*N-1:N];
      8'h04:        return '0;
      default:      return coe;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_out(input logic [7:0] op, input logic [2*N-1:0] u,
                                           input logic [N-1:0] co);
    return (op == 8'h00 || op == 8'h03) ? u[N-1:0] : co;
  endfunction

  function automatic bit is_bypass(input logic [7:0] op);
    return !(op == 8'h00 || op == 8'h01 || op == 8'h02);
  endfunction

  task automatic check_pads(input string req);
    @(negedge tck); #1;
    chk(pad_oe == exp_oe(cur_op, upd_m, core_oe, sys_rst_n), req, 64'(pad_oe),
        64'(exp_oe(cur_op, upd_m, core_oe, sys_rst_n)));
    chk(pad_out == exp_out(cur_op, upd_m, core_out), req, 64'(pad_out),
        64'(exp_out(cur_op, upd_m, core_out)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge tck);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  cap;
    logic [63:0] dout, din;
    logic [7:0]  ops [7];
    void'($urandom(32'd2024));
    ops[0] = 8'h00; ops[1] = 8'h01; ops[2] = 8'h02; ops[3] = 8'h03;
    ops[4] = 8'h04; ops[5] = 8'hFF; ops[6] = 8'h5A;
    cur_op = 8'h02; upd_m = '0;
    core_out = 8'hA5; core_oe = 8'h3C;
    repeat (3) @(posedge tck);
    @(negedge tck); trst_n = 1'b1;
    #1;
    chk(tdo_en == 1'b0, "R11 reset tdo_en", 64'(tdo_en), 0);
    check_pads("R11 reset pads follow core");
    step(0, 0);
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] == ID && dout[0], "R3 IDCODE after reset", dout, 64'(ID));
    @(negedge tck); #1;
    chk(tdo_en == 1'b0, "R10 tdo_en idle", 64'(tdo_en), 0);

    // EXTEST directed: preload via SAMPLE, then EXTEST
    scan_ir(8'h01, cap);
    chk(cap == 8'h01, "R2 capture pattern", 64'(cap), 64'h01);
    scan_dr(2*N, 64'hF0_0F, dout);
    chk(dout[2*N-1:0] == {core_oe, core_out}, "R5 sample capture", dout, 64'({core_oe, core_out}));
    check_pads("R5 sample pads follow core");
    scan_ir(8'h00, cap);
    check_pads("R6 extest drives update stage");
    sys_rst_n = 1'b0;
    check_pads("R9 system reset under extest");
    sys_rst_n = 1'b1;
    scan_ir(8'h03, cap);
    check_pads("R7 clamp drives update stage");
    scan_dr(5, 64'b10110, dout);
    chk(dout[4:0] == 5'b01100, "R7 clamp bypass path", dout, 64'b01100);
    sys_rst_n = 1'b0;
    check_pads("R9 system reset under clamp");
    sys_rst_n = 1'b1;
    scan_ir(8'h04, cap);
    check_pads("R8 highz");

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 6)];
      core_out = 8'($urandom); core_oe = 8'($urandom);
      sys_rst_n = ($urandom_range(0, 3) != 0);
      scan_ir(op, cap);
      chk(cap == 8'h01, "R2 capture pattern", 64'(cap), 64'h01);
      din = {$urandom, $urandom};
      if (op == 8'h02) begin
        scan_dr(32, din, dout);
        chk(dout[31:0] == ID, "R3 IDCODE", dout, 64'(ID));
      end else if (is_bypass(op)) begin
        scan_dr(9, din, dout);
        chk(dout[8:0] == {din[7:0], 1'b0}, "R4 bypass delay", dout, 64'({din[7:0], 1'b0}));
      end else begin
        scan_dr(2*N, din, dout);
        chk(dout[2*N-1:0] == {core_oe, core_out}, "R5 boundary capture", dout,
            64'({core_oe, core_out}));
      end
      check_pads(sys_rst_n ? "R6 pad selection" : "R9 pad override");
    end
    sys_rst_n = 1'b1;

    // TMS reset from inside Shift-DR
    scan_ir(8'h00, cap);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    repeat (5) step(1, 0);
    step(0, 0);
    cur_op = 8'h02;
    check_pads("R1 tms reset instruction");
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] == ID, "R1 IDCODE after tms reset", dout, 64'(ID));

    // asynchronous test reset mid-scan
    scan_ir(8'h00, cap);
    scan_dr(2*N, 64'hFFFF, dout);
    step(1, 0); step(0, 0);
    #2 trst_n = 1'b0;
    #1;
    chk(tdo_en == 1'b0, "R11 async tdo_en", 64'(tdo_en), 0);
    cur_op = 8'h02; upd_m = '0;
    check_pads("R11 async reset pads");
    @(negedge tck); trst_n = 1'b1;
    step(0, 0);
    scan_ir(8'h00, cap);
    check_pads("R11 update stage cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule